// File: doc/BRIEF.md
# SRAM Chip-Select Strobe Sequencer

This block drives the control timing of one external asynchronous SRAM-type memory area. A requester hands it one access at a time over a valid/ready port: address, a read/write flag and write data. The block then steps through an address-only setup phase, a chip-select phase that contains a single read or write strobe, and an address-only hold phase. It returns read data with a one-cycle done pulse. Every phase length comes from a configuration word. The strobe-active length uses a nonlinear 4-bit wait code.

Between accesses the block keeps the bus idle for a programmable number of cycles. The count depends on the kind of transition: write followed by anything, read followed by write, or read followed by read. For the two read cases it also depends on whether the new access hits the same area as the previous one. The area is the top `TAGW` bits of the address. All bus controls are registered and active-low. After reset the bus is idle.

Configuration word layout (`cfg`, 38 bits, each field an unsigned count):

| Bits | Meaning |
|---|---|
| [2:0] | address setup cycles before chip-select |
| [5:3] | address hold cycles after chip-select |
| [8:6] / [11:9] | read: chip-select to strobe / strobe to chip-select |
| [14:12] / [17:15] | write: chip-select to strobe / strobe to chip-select |
| [21:18] | strobe wait code |
| [22] | extra read-strobe cycle |
| [25:23] | idle after a write |
| [28:26] / [31:29] | idle read then write: same area / other area |
| [34:32] / [37:35] | idle read then read: same area / other area |

Top module: `sram_strobe_seq`

## Requirements
- R1: After reset `cs_n`, `rd_n` and `wr_n` are 1, and `addr_en` and `done` are 0. With no earlier access, `req_ready` is 1.
- R2: An accepted access drives its address on `mem_addr` with `addr_en`=1 for exactly cfg[2:0] cycles while `cs_n`=1, before `cs_n` falls. The address stays stable for the whole access.
- R3: After `cs_n` rises, `addr_en` stays 1 for exactly cfg[5:3] cycles before it drops.
- R4: On a read, `rd_n` falls exactly cfg[8:6] cycles after `cs_n` falls, and `cs_n` rises exactly cfg[11:9] cycles after `rd_n` rises. `wr_n` stays 1, `dq_oe` stays 0, and a strobe is low only while `cs_n` is low.
- R5: On a write, `wr_n` falls exactly cfg[14:12] cycles after `cs_n` falls, and `cs_n` rises exactly cfg[17:15] cycles after `wr_n` rises. `rd_n` stays 1, and while `wr_n` is low `dq_oe`=1 and `dq_out` equals the request's write data.
- R6: The strobe stays low for 1+W cycles. W is taken from cfg[21:18]: codes 0..9 give W=0..9, and codes 10..15 give 11,13,15,17,21,25.
- R7: When cfg[22]=1, a read strobe stays low for one cycle more than R6 gives. Writes are unaffected.
- R8: `done` pulses for one cycle in the first cycle after the access ends (`addr_en` low). On a read, `rdata` then equals the `dq_in` value present in the last cycle that `rd_n` was low.
- R9: After a write, the next access finds at least cfg[25:23]+1 cycles of `addr_en`=0 between accesses, and exactly that many when its request is already waiting.
- R10: After a read, a write finds cfg[28:26]+1 idle cycles when both addresses share the top `TAGW` bits, and cfg[31:29]+1 otherwise. Both counts are minimums, reached exactly when the request waits.
- R11: After a read, a read finds cfg[34:32]+1 idle cycles for the same area and cfg[37:35]+1 for a different area. Both counts are minimums, reached exactly when the request waits.
- R12: `req_ready` is 1 only while the bus is idle and the idle count of R9 to R11 has elapsed. The count is chosen from the waiting request and the live `cfg`. An accepted request makes the bus busy on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| cfg | input | 38 | timing configuration word |
| req_valid | input | 1 | request offered |
| req_ready | output | 1 | request taken this cycle when valid |
| req_we | input | 1 | 1 write, 0 read |
| req_addr | input | AW | access address; top TAGW bits are the area |
| req_wdata | input | DW | write data |
| done | output | 1 | one-cycle end-of-access pulse |
| rdata | output | DW | captured read data |
| mem_addr | output | AW | memory address |
| addr_en | output | 1 | address phase active |
| cs_n | output | 1 | chip-select, active low |
| rd_n | output | 1 | read strobe, active low |
| wr_n | output | 1 | write strobe, active low |
| dq_out | output | DW | write data to memory |
| dq_oe | output | 1 | write data drive enable |
| dq_in | input | DW | read data from memory |

## Verification
The assertions assume that `cfg` changes only while the bus is idle. Timing fields are latched at acceptance, but the idle count is read live. The stimulus therefore rewrites the configuration only between batches, after the previous batch has drained.

The assertions also assume the requester never withdraws a request that `req_ready` has already been granted. The driver holds each request until it is accepted, offers the next one right after, and so exercises the exact minimum idle gaps.

// File: rtl/sram_strobe_seq.sv
module sram_strobe_seq #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int TAGW = 2,
  localparam int CFGW = 38
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CFGW-1:0] cfg,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_we,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            done,
  output logic [DW-1:0]   rdata,
  output logic [AW-1:0]   mem_addr,
  output logic            addr_en,
  output logic            cs_n,
  output logic            rd_n,
  output logic            wr_n,
  output logic [DW-1:0]   dq_out,
  output logic            dq_oe,
  input  logic [DW-1:0]   dq_in
);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LEAD, S_STRB, S_TAIL, S_HOLD} st_t;

  function automatic logic [4:0] wait_map(input logic [3:0] c);
    case (c)
      4'd10:   wait_map = 5'd11;
      4'd11:   wait_map = 5'd13;
      4'd12:   wait_map = 5'd15;
      4'd13:   wait_map = 5'd17;
      4'd14:   wait_map = 5'd21;
      4'd15:   wait_map = 5'd25;
      default: wait_map = {1'b0, c};
    endcase
  endfunction

  st_t         st, nst;
  logic [4:0]  cnt, ncnt;
  logic [22:0] cfg_q, ccfg;
  logic        we_q, cwe, acc;
  logic [2:0]  gap, need;
  logic        have_prev, last_we;
  logic [TAGW-1:0] last_tag;
  logic        same_area;
  logic [4:0]  l_setup, l_hold, l_lead, l_tail, l_strb;

  assign ccfg = (st == S_IDLE) ? cfg[22:0] : cfg_q;
  assign cwe  = (st == S_IDLE) ? req_we : we_q;

  assign l_setup = {2'b0, ccfg[2:0]};
  assign l_hold  = {2'b0, ccfg[5:3]};
  assign l_lead  = cwe ? {2'b0, ccfg[14:12]} : {2'b0, ccfg[8:6]};
  assign l_tail  = cwe ? {2'b0, ccfg[17:15]} : {2'b0, ccfg[11:9]};
  assign l_strb  = 5'd1 + wait_map(ccfg[21:18]) + {4'b0, ~cwe & ccfg[22]};

  assign same_area = (req_addr[AW-1 -: TAGW] == last_tag);

  always_comb begin
    if (!have_prev)   need = 3'd0;
    else if (last_we) need = cfg[25:23];
    else if (req_we)  need = same_area ? cfg[28:26] : cfg[31:29];
    else              need = same_area ? cfg[34:32] : cfg[37:35];
  end

  assign req_ready = (st == S_IDLE) && (gap >= need);
  assign acc       = req_valid && req_ready;

  always_comb begin
    nst  = st;
    ncnt = cnt;
    if (st == S_IDLE) begin
      if (acc) begin
        if (l_setup != 5'd0) begin
          nst = S_SETUP; ncnt = l_setup - 5'd1;
        end else if (l_lead != 5'd0) begin
          nst = S_LEAD;  ncnt = l_lead - 5'd1;
        end else begin
          nst = S_STRB;  ncnt = l_strb - 5'd1;
        end
      end
    end else if (cnt != 5'd0) begin
      ncnt = cnt - 5'd1;
    end else begin
      case (st)
        S_SETUP:
          if (l_lead != 5'd0) begin
            nst = S_LEAD; ncnt = l_lead - 5'd1;
          end else begin
            nst = S_STRB; ncnt = l_strb - 5'd1;
          end
        S_LEAD: begin
          nst = S_STRB; ncnt = l_strb - 5'd1;
        end
        S_STRB:
          if (l_tail != 5'd0) begin
            nst = S_TAIL; ncnt = l_tail - 5'd1;
          end else if (l_hold != 5'd0) begin
            nst = S_HOLD; ncnt = l_hold - 5'd1;
          end else begin
            nst = S_IDLE; ncnt = 5'd0;
          end
        S_TAIL:
          if (l_hold != 5'd0) begin
            nst = S_HOLD; ncnt = l_hold - 5'd1;
          end else begin
            nst = S_IDLE; ncnt = 5'd0;
          end
        default: begin
          nst = S_IDLE; ncnt = 5'd0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= 5'd0;
      cfg_q     <= '0;
      we_q      <= 1'b0;
      mem_addr  <= '0;
      dq_out    <= '0;
      rdata     <= '0;
      done      <= 1'b0;
      addr_en   <= 1'b0;
      cs_n      <= 1'b1;
      rd_n      <= 1'b1;
      wr_n      <= 1'b1;
      dq_oe     <= 1'b0;
      gap       <= 3'd0;
      have_prev <= 1'b0;
      last_we   <= 1'b0;
      last_tag  <= '0;
    end else begin
      st      <= nst;
      cnt     <= ncnt;
      done    <= (st != S_IDLE) && (nst == S_IDLE);
      addr_en <= (nst != S_IDLE);
      cs_n    <= !(nst == S_LEAD || nst == S_STRB || nst == S_TAIL);
      rd_n    <= !(nst == S_STRB && !cwe);
      wr_n    <= !(nst == S_STRB && cwe);
      dq_oe   <= cwe && (nst == S_LEAD || nst == S_STRB || nst == S_TAIL);
      if (acc) begin
        cfg_q     <= cfg[22:0];
        we_q      <= req_we;
        mem_addr  <= req_addr;
        dq_out    <= req_wdata;
        have_prev <= 1'b1;
        last_we   <= req_we;
        last_tag  <= req_addr[AW-1 -: TAGW];
      end
      if (st == S_STRB && cnt == 5'd0 && !we_q)
        rdata <= dq_in;
      if (st != S_IDLE && nst == S_IDLE)
        gap <= 3'd0;
      else if (st == S_IDLE && gap != 3'd7)
        gap <= gap + 3'd1;
    end
  end

endmodule

// File: rtl/sram_strobe_seq_chk.sv
module sram_strobe_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          done,
  input logic [AW-1:0] mem_addr,
  input logic          addr_en,
  input logic          cs_n,
  input logic          rd_n,
  input logic          wr_n,
  input logic          dq_oe
);

  // R4
  strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> !cs_n);

  // R5
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R5
  drive_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !cs_n);

  // R2
  cs_in_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> addr_en);

  // R2
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_en && $past(addr_en)) |-> $stable(mem_addr));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cs_n && !addr_en));

  // R12
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (addr_en && !req_ready));

endmodule

bind sram_strobe_seq sram_strobe_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .mem_addr(mem_addr), .addr_en(addr_en), .cs_n(cs_n),
  .rd_n(rd_n), .wr_n(wr_n), .dq_oe(dq_oe)
);

// File: tb/sim_sram_strobe_seq.sv
module sim_sram_strobe_seq;
  localparam int CLK_NS = 10;
  localparam int AW = 16, DW = 16, TAGW = 2, CFGW = 38;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CFGW-1:0] cfg = '0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, dq_in = '0;
  logic req_ready, done, addr_en, cs_n, rd_n, wr_n, dq_oe;
  logic [DW-1:0] rdata, dq_out;
  logic [AW-1:0] mem_addr;

  sram_strobe_seq #(.AW(AW), .DW(DW), .TAGW(TAGW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .done(done),
    .rdata(rdata), .mem_addr(mem_addr), .addr_en(addr_en), .cs_n(cs_n),
    .rd_n(rd_n), .wr_n(wr_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in));

  always #(CLK_NS/2) clk = ~clk;

  int total = 0, bad = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  typedef struct {
    bit we;
    logic [AW-1:0] addr;
    logic [DW-1:0] wd;
    logic [CFGW-1:0] c;
    bit gapchk;
    int gexp;
    int gtag;
  } op_t;

  op_t q[$];
  op_t cur;

  function automatic int wmap(input logic [3:0] code);
    case (code)
      4'd10: return 11;
      4'd11: return 13;
      4'd12: return 15;
      4'd13: return 17;
      4'd14: return 21;
      4'd15: return 25;
      default: return int'(code);
    endcase
  endfunction

  function automatic int need_of(input bit pw, input int pt, input bit w, input int t,
                                 input logic [CFGW-1:0] c, output int tg);
    if (pw) begin tg = 9; return int'(c[25:23]); end
    if (w) begin tg = 10; return (pt == t) ? int'(c[28:26]) : int'(c[31:29]); end
    tg = 11;
    return (pt == t) ? int'(c[34:32]) : int'(c[37:35]);
  endfunction

  function automatic string gname(input int g);
    if (g == 9) return "R9";
    if (g == 10) return "R10";
    return "R11";
  endfunction

  bit have_prev = 0, prev_we = 0;
  int prev_tag = 0;

  task automatic issue(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    op_t o;
    int tg;
    @(negedge clk);
    req_we = we; req_addr = a; req_wdata = d; req_valid = 1'b1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    o.we = we; o.addr = a; o.wd = d; o.c = cfg; o.gapchk = have_prev;
    o.gexp = 0; o.gtag = 9;
    if (have_prev) begin
      o.gexp = need_of(prev_we, prev_tag, we, int'(a[AW-1 -: TAGW]), cfg, tg) + 1;
      o.gtag = tg;
    end
    q.push_back(o);
    have_prev = 1; prev_we = we; prev_tag = int'(a[AW-1 -: TAGW]);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // monitor: measures phase lengths at the falling edge
  bit in_acc = 0, seen_cs = 0, seen_st = 0, oe_bad = 0, wd_bad = 0;
  int n_setup, n_lead, n_strb, n_tail, n_hold, n_gap = 0;
  logic [DW-1:0] last_rd = '0;

  always @(negedge clk) begin
    dq_in = DW'($urandom);
    if (rst_n) begin
      if (addr_en) begin
        if (!in_acc) begin
          in_acc = 1; seen_cs = 0; seen_st = 0; oe_bad = 0; wd_bad = 0;
          n_setup = 0; n_lead = 0; n_strb = 0; n_tail = 0; n_hold = 0;
          cur = q[0];
          chk("R2", "address", int'(mem_addr), int'(cur.addr));
          if (cur.gapchk) chk(gname(cur.gtag), "idle gap", n_gap, cur.gexp);
        end
        if (cs_n) begin
          if (!seen_cs) n_setup++; else n_hold++;
        end else begin
          seen_cs = 1;
          if (!rd_n || !wr_n) begin
            seen_st = 1; n_strb++;
            if (cur.we) begin
              if (!rd_n || !dq_oe || dq_out != cur.wd) wd_bad = 1;
            end else begin
              if (!wr_n) wd_bad = 1;
              last_rd = dq_in;
            end
          end else if (!seen_st) n_lead++;
          else n_tail++;
        end
        if (!cur.we && dq_oe) oe_bad = 1;
      end else if (in_acc) begin
        int sexp;
        in_acc = 0;
        void'(q.pop_front());
        sexp = 1 + wmap(cur.c[21:18]) + ((!cur.we && cur.c[22]) ? 1 : 0);
        chk("R2", "setup", n_setup, int'(cur.c[2:0]));
        chk("R3", "hold", n_hold, int'(cur.c[5:3]));
        chk("R8", "done", int'(done), 1);
        if (cur.we) begin
          chk("R5", "write lead", n_lead, int'(cur.c[14:12]));
          chk("R5", "write tail", n_tail, int'(cur.c[17:15]));
          chk("R5", "write strobe/data", int'(wd_bad), 0);
          chk("R6", "write strobe len", n_strb, sexp);
        end else begin
          chk("R4", "read lead", n_lead, int'(cur.c[8:6]));
          chk("R4", "read tail", n_tail, int'(cur.c[11:9]));
          chk("R4", "read strobe/oe", int'(wd_bad | oe_bad), 0);
          if (cur.c[22]) chk("R7", "read strobe len", n_strb, sexp);
          else           chk("R6", "read strobe len", n_strb, sexp);
          chk("R8", "rdata", int'(rdata), int'(last_rd));
        end
        n_gap = 1;
      end else begin
        n_gap++;
      end
    end
  end

  task automatic drain;
    do @(negedge clk); while (q.size() != 0 || in_acc);
    repeat (2) @(negedge clk);
  endtask

  task automatic new_cfg(input logic [CFGW-1:0] c);
    @(negedge clk);
    cfg = c;
    have_prev = 0;
  endtask

  function automatic logic [AW-1:0] mk_addr(input int tag);
    return {TAGW'(tag), (AW-TAGW)'($urandom)};
  endfunction

  task automatic rand_ops(input int n);
    for (int i = 0; i < n; i++)
      issue(bit'($urandom % 2), mk_addr(int'($urandom % 3 == 0 ? 2 : 1)), DW'($urandom));
  endtask

  initial begin
    void'($urandom(32'd7349));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "cs_n", int'(cs_n), 1);
    chk("R1", "rd_n", int'(rd_n), 1);
    chk("R1", "wr_n", int'(wr_n), 1);
    chk("R1", "addr_en", int'(addr_en), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "req_ready", int'(req_ready), 1);
    rst_n = 1'b1;

    // all-zero timing: shortest accesses and gaps
    new_cfg('0);
    issue(1'b1, mk_addr(1), 16'h1234);
    issue(1'b0, mk_addr(1), 16'h0);
    issue(1'b0, mk_addr(1), 16'h0);
    issue(1'b1, mk_addr(2), 16'hBEEF);
    drain();

    // all fields at maximum
    new_cfg({CFGW{1'b1}});
    issue(1'b0, mk_addr(0), 16'h0);
    issue(1'b0, mk_addr(3), 16'h0);
    issue(1'b1, mk_addr(3), 16'hA5A5);
    issue(1'b0, mk_addr(3), 16'h0);
    drain();

    // distinct same/different gap counts, R10 and R11 corners
    new_cfg({3'd6, 3'd2, 3'd5, 3'd1, 3'd3, 1'b0, 4'd3, 18'h0});
    issue(1'b0, mk_addr(1), 16'h0);
    issue(1'b0, mk_addr(1), 16'h0);
    issue(1'b0, mk_addr(2), 16'h0);
    issue(1'b1, mk_addr(2), 16'h5555);
    issue(1'b0, mk_addr(2), 16'h0);
    issue(1'b1, mk_addr(1), 16'hAAAA);
    issue(1'b1, mk_addr(1), 16'h0F0F);
    drain();

    // R6 every wait code, R7 both settings
    for (int code = 0; code < 16; code++) begin
      new_cfg({15'($urandom), 1'(code % 2), 4'(code), 18'($urandom)});
      issue(1'b0, mk_addr(1), 16'h0);
      issue(1'b1, mk_addr(2), DW'($urandom));
      drain();
    end

    // random configurations and traffic
    for (int b = 0; b < 30; b++) begin
      new_cfg({6'($urandom), 32'($urandom)});
      rand_ops(8);
      drain();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule